// File: doc/BRIEF.md
# Prescaled Match-Capture Timer Counter

This block is a 32-bit timer/counter for a peripheral bus. A prescaler divides the count source, and a main counter advances once for each prescaler wrap. Four compare channels watch the main counter. When a channel hits, it can flag an interrupt, return the counter to zero, or halt counting, in any combination. Two capture inputs are synchronized and edge-detected. Each can copy the main counter into its own capture register on a rising edge, a falling edge or both.

The count source is either the clock itself (timer mode) or edges on one chosen capture input (edge-count mode). Four output pins hold external-match levels. On each hit, a pin can be cleared, set or toggled. A pin can instead be switched to pulse-width mode. In that mode it goes high on its own hit and low whenever a compare channel returns the counter to zero.

Software reaches every register through a single-cycle write strobe and a combinational read port on byte addresses.

Top module: `mcap_timer`

## Requirements
- R1: After reset every readable register reads zero, `match_out` is 0 and `irq` is 0.
- R2: In timer mode with the counter running, the prescale counter steps 0,1,..,P and the main counter increments on the clock where the prescale counter equals P (address 0x0C). At that same clock the prescale counter returns to 0, so the main counter advances once every P+1 clocks.
- R3: Bit 0 of the control register (0x04) enables counting and bit 1 holds both counters at zero. With both bits 0 the counters keep their values. The main counter (0x08) and prescale counter (0x10) can be written and read back.
- R4: Compare channel i (value at 0x18+4i) hits on a counter advance taken while the main counter equals its value. The match control register (0x14) holds three bits per channel: bit 3i enables the flag, bit 3i+1 returns the counter to 0 instead of incrementing, and bit 3i+2 halts counting. A channel that returns the counter to value V therefore gives a period of V+1 advances.
- R5: A halting hit clears control bit 0 and leaves the main counter at the compare value.
- R6: Capture control (0x28) holds three bits per input j: bit 3j selects rising edges, bit 3j+1 selects falling edges, and bit 3j+2 enables the flag. On a selected edge, capture register j (0x2C+8j) loads the main counter value. An edge that is not selected leaves the capture register unchanged.
- R7: The flag register (0x00) holds match flags in bits 3:0 and capture flags in bits 5:4. Writing 1 to a bit clears it, but a new event in the same clock keeps it set. Flags persist until cleared. `irq` is high while any flag is set.
- R8: Count mode (0x70): bits 1:0 select the count source (0 = clock, 1 = rising edges, 2 = falling edges, 3 = both edges). Bit 2 selects capture input 0 or 1 as the edge source.
- R9: External match (0x3C): bits 3:0 are the pin levels driven on `match_out` and are writable. Bits 5+2i:4+2i give channel i's action on a hit: 0 none, 1 clear, 2 set, 3 toggle.
- R10: When bit i of the pulse-width register (0x74) is set, pin i goes high on channel i's hit and low on any hit that returns the counter to zero. Its action field is ignored.
- R11: Compare, prescale, count-mode and pulse-width registers read back the values written at the offsets given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_in | input | 2 | Asynchronous capture / count inputs |
| match_out | output | 4 | External match / pulse-width pins |
| irq | output | 1 | High while any flag is pending |

## Verification
The bench sweeps several prescale values across a dozen clocks. A prescaler that wrapped one count late or early would show up as a drifting main counter.

Compare channels are exercised in three ways:
- with return-to-zero periods, which catch a design that compares after the increment and runs one count long;
- with a halting hit, which catches a counter that overshoots the compare value;
- with toggle, set and pulse-width pins, which catch an action applied on the wrong clock or a pulse-width pin that obeys its action field.

Capture is tested with unselected edges, where a design that ignores the edge selection overwrites the stored value. Edge-count mode is tested with each edge choice and with both inputs, which catches a wrong input select or an edge that is counted twice.

// File: rtl/mcap_pkg.sv
package mcap_pkg;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] A_FLAG  = 7'h00;
  localparam logic [ADDR_W-1:0] A_CTRL  = 7'h04;
  localparam logic [ADDR_W-1:0] A_CNT   = 7'h08;
  localparam logic [ADDR_W-1:0] A_PRE   = 7'h0C;
  localparam logic [ADDR_W-1:0] A_PCNT  = 7'h10;
  localparam logic [ADDR_W-1:0] A_MCTL  = 7'h14;
  localparam logic [ADDR_W-1:0] A_CMP0  = 7'h18;
  localparam logic [ADDR_W-1:0] A_CCTL  = 7'h28;
  localparam logic [ADDR_W-1:0] A_CAP0  = 7'h2C;
  localparam logic [ADDR_W-1:0] A_EXTM  = 7'h3C;
  localparam logic [ADDR_W-1:0] A_CMODE = 7'h70;
  localparam logic [ADDR_W-1:0] A_PWM   = 7'h74;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } ext_act_e;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } cnt_src_e;
endpackage

// File: rtl/mcap_edge.sv
module mcap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [2:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/mcap_prescale.sv
module mcap_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         run,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pc,
  output logic         tick
);
  logic [W-1:0] pc_q, pc_d;

  always_comb begin
    tick = run && evt && !wr_en && (pc_q == limit);
    pc_d = pc_q;
    if (wr_en)           pc_d = wr_val;
    else if (clr)        pc_d = '0;
    else if (run && evt) pc_d = tick ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/mcap_pin.sv
module mcap_pin
  import mcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       cnt_rst,
  input  logic       pwm_en,
  input  logic [1:0] act,
  input  logic       wr_en,
  input  logic       wr_val,
  output logic       pin
);
  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    if (wr_en) begin
      pin_d = wr_val;
    end else if (pwm_en) begin
      if (hit)          pin_d = 1'b1;
      else if (cnt_rst) pin_d = 1'b0;
    end else if (hit) begin
      case (ext_act_e'(act))
        ACT_CLR: pin_d = 1'b0;
        ACT_SET: pin_d = 1'b1;
        ACT_TGL: pin_d = ~pin_q;
        default: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;
endmodule

// File: rtl/mcap_timer.sv
module mcap_timer
  import mcap_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_MAT = 4,
  parameter int N_CAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_CAP-1:0]  cap_in,
  output logic [N_MAT-1:0]  match_out,
  output logic              irq
);
  localparam int NF   = N_MAT + N_CAP;
  localparam int MC_W = 3 * N_MAT;
  localparam int CC_W = 3 * N_CAP;
  localparam int EA_W = 2 * N_MAT;

  logic [1:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] tc_q, tc_d, pr_q, pr_d, pc_cnt;
  logic [MC_W-1:0]  mctl_q, mctl_d;
  logic [CC_W-1:0]  cctl_q, cctl_d;
  logic [EA_W-1:0]  eact_q, eact_d;
  logic [2:0]       cmode_q, cmode_d;
  logic [N_MAT-1:0] pwm_q, pwm_d;
  logic [NF-1:0]    flag_q, flag_d;
  logic [CNT_W-1:0] cmp_q [N_MAT];
  logic [CNT_W-1:0] cap_q [N_CAP];

  logic [N_CAP-1:0] c_rise, c_fall, cap_evt, cap_irq;
  logic [N_MAT-1:0] hit, m_irq, m_rst, m_stop;
  logic             cnt_evt, tick, any_rst, any_stop, run;
  logic             wr_flag, wr_ctrl, wr_cnt, wr_pcnt, wr_extm;

  assign wr_flag = bus_wr && (bus_addr == A_FLAG);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_cnt  = bus_wr && (bus_addr == A_CNT);
  assign wr_pcnt = bus_wr && (bus_addr == A_PCNT);
  assign wr_extm = bus_wr && (bus_addr == A_EXTM);
  assign run     = ctrl_q[0] & ~ctrl_q[1];

  // capture inputs: synchronizer, edge select, capture register
  for (genvar gj = 0; gj < N_CAP; gj++) begin : g_cap
    logic [CNT_W-1:0] cap_d;
    mcap_edge u_edge (
      .clk (clk), .rst_n(rst_n), .din(cap_in[gj]),
      .rise(c_rise[gj]), .fall(c_fall[gj])
    );
    assign cap_evt[gj] = (c_rise[gj] & cctl_q[3*gj]) | (c_fall[gj] & cctl_q[3*gj+1]);
    assign cap_irq[gj] = cctl_q[3*gj+2];
    assign cap_d       = cap_evt[gj] ? tc_q : cap_q[gj];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q[gj] <= '0;
      else        cap_q[gj] <= cap_d;
    end
  end

  // count source
  always_comb begin
    case (cnt_src_e'(cmode_q[1:0]))
      SRC_CLK:  cnt_evt = 1'b1;
      SRC_RISE: cnt_evt = c_rise[cmode_q[2]];
      SRC_FALL: cnt_evt = c_fall[cmode_q[2]];
      default:  cnt_evt = c_rise[cmode_q[2]] | c_fall[cmode_q[2]];
    endcase
  end

  mcap_prescale #(.W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .evt(cnt_evt), .run(run), .clr(ctrl_q[1]),
    .wr_en(wr_pcnt), .wr_val(bus_wdata), .limit(pr_q), .pc(pc_cnt), .tick(tick)
  );

  // compare channels and output pins
  for (genvar gi = 0; gi < N_MAT; gi++) begin : g_mat
    assign m_irq[gi]  = mctl_q[3*gi];
    assign m_rst[gi]  = mctl_q[3*gi+1];
    assign m_stop[gi] = mctl_q[3*gi+2];
    assign hit[gi]    = tick && (tc_q == cmp_q[gi]);
    mcap_pin u_pin (
      .clk(clk), .rst_n(rst_n), .hit(hit[gi]), .cnt_rst(any_rst),
      .pwm_en(pwm_q[gi]), .act(eact_q[2*gi +: 2]),
      .wr_en(wr_extm), .wr_val(bus_wdata[gi]), .pin(match_out[gi])
    );
  end

  assign any_rst  = |(hit & m_rst);
  assign any_stop = |(hit & m_stop);

  // next state
  always_comb begin
    ctrl_d  = ctrl_q;
    tc_d    = tc_q;
    pr_d    = pr_q;
    mctl_d  = mctl_q;
    cctl_d  = cctl_q;
    eact_d  = eact_q;
    cmode_d = cmode_q;
    pwm_d   = pwm_q;

    if (wr_ctrl)       ctrl_d = bus_wdata[1:0];
    else if (any_stop) ctrl_d[0] = 1'b0;

    if (wr_cnt)         tc_d = bus_wdata;
    else if (ctrl_q[1]) tc_d = '0;
    else if (tick)      tc_d = any_rst ? '0 : (any_stop ? tc_q : tc_q + 1'b1);

    if (bus_wr) begin
      case (bus_addr)
        A_PRE:   pr_d    = bus_wdata;
        A_MCTL:  mctl_d  = bus_wdata[MC_W-1:0];
        A_CCTL:  cctl_d  = bus_wdata[CC_W-1:0];
        A_EXTM:  eact_d  = bus_wdata[N_MAT +: EA_W];
        A_CMODE: cmode_d = bus_wdata[2:0];
        A_PWM:   pwm_d   = bus_wdata[N_MAT-1:0];
        default: ;
      endcase
    end

    flag_d = (flag_q & ~(wr_flag ? bus_wdata[NF-1:0] : '0))
           | {cap_evt & cap_irq, hit & m_irq};
  end

  logic [CNT_W-1:0] cmp_d [N_MAT];
  always_comb begin
    for (int i = 0; i < N_MAT; i++) begin
      cmp_d[i] = cmp_q[i];
      if (bus_wr && bus_addr == A_CMP0 + ADDR_W'(4*i)) cmp_d[i] = bus_wdata;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tc_q    <= '0;
      pr_q    <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
      eact_q  <= '0;
      cmode_q <= '0;
      pwm_q   <= '0;
      flag_q  <= '0;
      for (int i = 0; i < N_MAT; i++) cmp_q[i] <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      tc_q    <= tc_d;
      pr_q    <= pr_d;
      mctl_q  <= mctl_d;
      cctl_q  <= cctl_d;
      eact_q  <= eact_d;
      cmode_q <= cmode_d;
      pwm_q   <= pwm_d;
      flag_q  <= flag_d;
      for (int i = 0; i < N_MAT; i++) cmp_q[i] <= cmp_d[i];
    end
  end

  assign irq = |flag_q;

  // read port
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_FLAG:  bus_rdata[NF-1:0]           = flag_q;
      A_CTRL:  bus_rdata[1:0]              = ctrl_q;
      A_CNT:   bus_rdata                   = tc_q;
      A_PRE:   bus_rdata                   = pr_q;
      A_PCNT:  bus_rdata                   = pc_cnt;
      A_MCTL:  bus_rdata[MC_W-1:0]         = mctl_q;
      A_CCTL:  bus_rdata[CC_W-1:0]         = cctl_q;
      A_EXTM:  bus_rdata[N_MAT+EA_W-1:0]   = {eact_q, match_out};
      A_CMODE: bus_rdata[2:0]              = cmode_q;
      A_PWM:   bus_rdata[N_MAT-1:0]        = pwm_q;
      default: ;
    endcase
    for (int i = 0; i < N_MAT; i++)
      if (bus_addr == A_CMP0 + ADDR_W'(4*i)) bus_rdata = cmp_q[i];
    for (int j = 0; j < N_CAP; j++)
      if (bus_addr == A_CAP0 + ADDR_W'(8*j)) bus_rdata = cap_q[j];
  end
endmodule

// File: rtl/mcap_timer_chk.sv
module mcap_timer_chk
  import mcap_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NF    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [1:0]        ctrl,
  input logic [2:0]        cmode,
  input logic [CNT_W-1:0]  tc,
  input logic [CNT_W-1:0]  pc,
  input logic [CNT_W-1:0]  pr,
  input logic              hit_stop,
  input logic [NF-1:0]     flags,
  input logic              cap_evt0,
  input logic [CNT_W-1:0]  cap0
);
  logic wr_tc, wr_pc, wr_ct;
  assign wr_tc = bus_wr && (bus_addr == A_CNT);
  assign wr_pc = bus_wr && (bus_addr == A_PCNT);
  assign wr_ct = bus_wr && (bus_addr == A_CTRL);

  // R2: below the limit the prescaler steps by one and the main counter waits
  p_prescale_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 2'b01 && cmode[1:0] == 2'b00 && pc < pr && !wr_tc && !wr_pc && !wr_ct)
    |=> (pc == $past(pc) + 1'b1 && $stable(tc)));

  // R3: hold forces zero
  p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1] && !wr_tc) |=> (tc == '0));

  // R3: disabled counters keep their values
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 2'b00 && !wr_tc && !wr_pc) |=> ($stable(tc) && $stable(pc)));

  // R5: a halting hit clears the enable
  p_stop_clears_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stop && !wr_ct) |=> !ctrl[0]);

  // R6: capture takes the counter value of the event clock
  p_cap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt0 |=> (cap0 == $past(tc)));

  // R7: flags persist until a one is written to them
  for (genvar k = 0; k < NF; k++) begin : g_flag
    p_flag_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[k] && !(bus_wr && bus_addr == A_FLAG && bus_wdata[k])) |=> flags[k]);
  end
endmodule

bind mcap_timer mcap_timer_chk #(.CNT_W(CNT_W), .NF(N_MAT + N_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl(ctrl_q), .cmode(cmode_q), .tc(tc_q),
  .pc(pc_cnt), .pr(pr_q), .hit_stop(any_stop), .flags(flag_q),
  .cap_evt0(cap_evt[0]), .cap0(cap_q[0])
);

// File: tb/sim_mcap_timer.sv
module sim_mcap_timer;
  import mcap_pkg::*;

  logic        clk, rst_n, bus_wr, irq;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rv;
  logic [1:0]  cap_in;
  logic [3:0]  match_out;
  int n_vec = 0;
  int n_bad = 0;

  mcap_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .match_out(match_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic start();
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); cap_in[idx] = 1'b1;
    repeat (4) @(negedge clk);
    cap_in[idx] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; cap_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 32'h78; a += 4) begin
      rd(7'(a), rv);
      chk("R1 reg reset", rv, 32'h0);
    end
    chk("R1 pins reset", {28'h0, match_out}, 32'h0);
    chk("R1 irq reset", {31'h0, irq}, 32'h0);

    // R11: readback of configuration registers
    for (int i = 0; i < 4; i++) wr(A_CMP0 + 7'(4*i), 32'hA000_0000 + 32'(i));
    wr(A_PRE, 32'h0BAD_F00D);
    wr(A_CMODE, 32'h5);
    wr(A_PWM, 32'hA);
    for (int i = 0; i < 4; i++) begin
      rd(A_CMP0 + 7'(4*i), rv);
      chk("R11 compare readback", rv, 32'hA000_0000 + 32'(i));
    end
    rd(A_PRE, rv);   chk("R11 prescale readback", rv, 32'h0BAD_F00D);
    rd(A_CMODE, rv); chk("R11 mode readback", rv, 32'h5);
    rd(A_PWM, rv);   chk("R11 pwm readback", rv, 32'hA);
    wr(A_CMODE, 0); wr(A_PWM, 0);
    for (int i = 0; i < 4; i++) wr(A_CMP0 + 7'(4*i), 32'hFFFF_FFFF);

    // R2: prescale sweep
    for (int p = 0; p < 4; p++) begin
      wr(A_PRE, 32'(p));
      start();
      for (int m = 0; m < 12; m++) begin
        rd(A_CNT, rv);  chk("R2 main count", rv, 32'(m / (p + 1)));
        rd(A_PCNT, rv); chk("R2 prescale count", rv, 32'(m % (p + 1)));
        @(negedge clk);
      end
    end

    // R3: freeze, write, hold
    wr(A_CTRL, 0);
    rd(A_CNT, rv);
    begin
      logic [31:0] frz;
      frz = rv;
      repeat (5) @(negedge clk);
      rd(A_CNT, rv); chk("R3 frozen count", rv, frz);
    end
    wr(A_CNT, 32'h99); wr(A_PCNT, 32'h1);
    rd(A_CNT, rv);  chk("R3 count write", rv, 32'h99);
    rd(A_PCNT, rv); chk("R3 prescale write", rv, 32'h1);
    wr(A_CTRL, 32'h3);
    repeat (3) @(negedge clk);
    rd(A_CNT, rv);  chk("R3 hold count", rv, 32'h0);
    rd(A_PCNT, rv); chk("R3 hold prescale", rv, 32'h0);

    // R4: return-to-zero compare with flag
    wr(A_CTRL, 0); wr(A_PRE, 0);
    wr(A_CMP0, 4); wr(A_MCTL, 32'h3); wr(A_FLAG, 32'h3F);
    start();
    for (int m = 0; m < 13; m++) begin
      rd(A_CNT, rv);  chk("R4 periodic count", rv, 32'(m % 5));
      rd(A_FLAG, rv); chk("R4 match flag", {31'h0, rv[0]}, (m >= 5) ? 32'h1 : 32'h0);
      @(negedge clk);
    end
    // R7: write-one-to-clear
    wr(A_CTRL, 0);
    chk("R7 irq pending", {31'h0, irq}, 32'h1);
    wr(A_FLAG, 32'h1);
    rd(A_FLAG, rv); chk("R7 flag cleared", rv, 32'h0);
    chk("R7 irq released", {31'h0, irq}, 32'h0);

    // R5: halting compare
    wr(A_CMP1_dummy(), 3);
    wr(A_MCTL, 32'h28);
    start();
    repeat (8) @(negedge clk);
    rd(A_CNT, rv);  chk("R5 halted count", rv, 32'h3);
    rd(A_CTRL, rv); chk("R5 enable cleared", rv, 32'h0);
    rd(A_FLAG, rv); chk("R5 halt flag", rv, 32'h2);
    wr(A_FLAG, 32'h3F);

    // R6: capture edges
    wr(A_MCTL, 0);
    wr(A_CCTL, 32'h15);
    wr(A_CNT, 32'h1234);
    @(negedge clk); cap_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_CAP0, rv); chk("R6 rising capture", rv, 32'h1234);
    rd(A_FLAG, rv); chk("R7 capture flag", rv, 32'h10);
    wr(A_CNT, 32'h55);
    cap_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_CAP0, rv); chk("R6 unselected fall ignored", rv, 32'h1234);
    cap_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_CAP0 + 7'd8, rv); chk("R6 unselected rise ignored", rv, 32'h0);
    wr(A_CNT, 32'h77);
    cap_in[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_CAP0 + 7'd8, rv); chk("R6 falling capture", rv, 32'h77);
    rd(A_FLAG, rv); chk("R7 no flag without enable", rv, 32'h10);
    wr(A_FLAG, 32'h10);
    rd(A_FLAG, rv); chk("R7 capture flag cleared", rv, 32'h0);

    // R8: edge-count modes
    wr(A_CCTL, 0);
    wr(A_CMODE, 32'h1); start();
    for (int k = 0; k < 3; k++) pulse(0);
    rd(A_CNT, rv); chk("R8 rising count", rv, 32'h3);
    wr(A_CMODE, 32'h3); start();
    for (int k = 0; k < 2; k++) pulse(0);
    rd(A_CNT, rv); chk("R8 both-edge count", rv, 32'h4);
    wr(A_CMODE, 32'h6); start();
    for (int k = 0; k < 2; k++) pulse(1);
    pulse(0);
    rd(A_CNT, rv); chk("R8 falling count on input 1", rv, 32'h2);
    wr(A_CMODE, 0);

    // R9: external match actions
    wr(A_CTRL, 0);
    wr(A_EXTM, 0);
    wr(A_CMP0 + 7'd8, 2); wr(A_CMP0 + 7'd12, 1);
    wr(A_MCTL, 32'h80);
    wr(A_EXTM, 32'hB00);
    start();
    for (int m = 0; m < 10; m++) begin
      chk("R9 toggle pin", {31'h0, match_out[2]}, 32'((m / 3) % 2));
      chk("R9 set pin", {31'h0, match_out[3]}, (m >= 2) ? 32'h1 : 32'h0);
      @(negedge clk);
    end

    // R10: pulse-width pin
    wr(A_CTRL, 0);
    wr(A_EXTM, 32'h30);
    wr(A_CMP0, 1); wr(A_CMP0 + 7'd12, 3);
    wr(A_MCTL, 32'h400);
    wr(A_PWM, 32'h1);
    start();
    for (int m = 0; m < 12; m++) begin
      chk("R10 pwm pin", {31'h0, match_out[0]}, ((m % 4) >= 2) ? 32'h1 : 32'h0);
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  function automatic logic [6:0] A_CMP1_dummy();
    return A_CMP0 + 7'd4;
  endfunction
endmodule